// File: doc/BRIEF.md
# DMA hold-acknowledge arbiter

This block decides when the processor's bus may be lent to a DMA controller. A grant is allowed only in a bus cycle where the processor is idle and not locked, and only while the DMA controller is asking for the bus. The block decodes its own chip select for the DMA controller's I/O register window from the I/O address. It drives a hold-acknowledge to the DMA controller and a wait request that stalls the processor for as long as the grant is in flight or held.

A compile-time parameter chooses between two behaviours. The early behaviour grants only on the idle/unlocked/requested condition. The revised behaviour adds an override: any processor I/O write that hits the DMA controller's register window forces the grant condition true. Without the override, a register write that coincides with a DMA request can leave both parties waiting on each other forever. The processor holds its write cycle open until the DMA controller responds, and the DMA controller waits for a hold-acknowledge that never comes because the bus is never idle. The captured condition passes through a fixed three-flop pipeline before it reaches the hold-acknowledge pin.

Top module: `dma_hold_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every pipeline flop. While reset is held and after it is released with no request, `hold_ack` and `cpu_wait` are 0.
- R2: The grant condition is true when `bus_status` equals 2'b11 (idle processor cycle), `lock_n` is 1 and `hold_req` is 1. `hold_ack` goes to 1 after the third rising edge that samples a true condition, and it stays 0 after the first two such edges.
- R3: While `lock_n` is 0, or while `bus_status` is any value other than 2'b11, a pending `hold_req` produces no `hold_ack` unless the R4 override applies.
- R4: With REVISION=1, the grant condition is also true whenever `dma_cs_n` and `iow_n` are both 0. This holds whatever the values of `bus_status`, `lock_n` and `hold_req`. A register write with `hold_req` pending therefore receives `hold_ack` three edges later.
- R5: With REVISION=0 there is no override. A DMA-register write (`dma_cs_n`=0, `iow_n`=0) during an active `bus_status` never raises `hold_ack`, however long it lasts.
- R6: `dma_cs_n` is 0 exactly when `io_addr` lies in 0x000..0x01F and is 1 for every other address, including 0x020 and 0x3FF.
- R7: Once the grant condition becomes false, `hold_ack` is 0 no later than after the third rising edge.
- R8: `cpu_wait` is 1 from the first edge that captures a true condition and remains 1 while `hold_ack` is 1. It falls in the same cycle that `hold_ack` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every flop uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_status | input | 2 | Processor status pair; 2'b11 marks an idle cycle |
| lock_n | input | 1 | Processor bus lock, active low |
| hold_req | input | 1 | Bus request from the DMA controller, active high |
| io_addr | input | ADDR_W (10) | I/O address from the processor |
| iow_n | input | 1 | I/O write strobe, active low |
| dma_cs_n | output | 1 | Decoded DMA controller register select, active low |
| hold_ack | output | 1 | Hold-acknowledge to the DMA controller |
| cpu_wait | output | 1 | Wait request to the processor |

## Verification
The embedded properties assume that every input is steady around the rising clock edge. They also assume that reset is held for at least one edge before any check counts cycles. The exact-latency property further relies on the request and status lines being free of glitches between edges. The bench meets these assumptions by changing inputs only on the falling edge and by holding reset for several cycles with a request pending. For the stall case, the bench acts as a processor that keeps its register write open until it sees the acknowledge, and it runs the early and revised variants side by side on identical inputs.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

    localparam logic [1:0] IDLE_STATUS = 2'b11;

    typedef struct packed {
        logic idle;
        logic unlocked;
        logic request;
        logic reg_write;
    } grant_terms_t;

    function automatic logic is_idle(input logic [1:0] status);
        return status == IDLE_STATUS;
    endfunction

    function automatic logic basic_grant(input grant_terms_t t);
        return t.idle && t.unlocked && t.request;
    endfunction

endpackage

// File: rtl/hold_cs_decode.sv
module hold_cs_decode #(
    parameter int ADDR_W = 10,
    parameter int WIN_BASE = 0,
    parameter int WIN_SPAN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              dma_cs_n
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(WIN_SPAN);
    localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(WIN_BASE + WIN_SPAN - 1);

    logic [ADDR_W-1:0] offset;

    // Subtracting the base folds the two bound checks into one compare.
    assign offset   = io_addr - BASE_V;
    assign dma_cs_n = !(offset < SPAN_V);

    // R6: an address above the window never selects the DMA controller.
    assert_no_select_above_R6: assert property (@(posedge clk) disable iff (rst)
        (io_addr > LAST_V) |-> dma_cs_n);

endmodule

// File: rtl/hold_grant_logic.sv
module hold_grant_logic
    import hold_arb_pkg::*;
#(
    parameter int REVISION = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_status,
    input  logic       lock_n,
    input  logic       hold_req,
    input  logic       dma_cs_n,
    input  logic       iow_n,
    output logic       grant
);
    grant_terms_t terms;

    always_comb begin
        terms.idle      = is_idle(bus_status);
        terms.unlocked  = lock_n;
        terms.request   = hold_req;
        terms.reg_write = !dma_cs_n && !iow_n;
    end

    generate
        if (REVISION != 0) begin : g_revised
            assign grant = basic_grant(terms) || terms.reg_write;

            // R4: a DMA-register write always forces the grant condition.
            assert_write_forces_R4: assert property (@(posedge clk) disable iff (rst)
                (!dma_cs_n && !iow_n) |-> grant);
        end else begin : g_early
            assign grant = basic_grant(terms);

            // R5: a register write during an active cycle cannot grant.
            assert_no_override_R5: assert property (@(posedge clk) disable iff (rst)
                (!is_idle(bus_status) && terms.reg_write) |-> !grant);
        end
    endgenerate

    // R3: locked or active cycles block the grant unless a register write overrides.
    assert_locked_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        ((!lock_n || !is_idle(bus_status)) && !(!dma_cs_n && !iow_n)) |-> !grant);

endmodule

// File: rtl/hold_sync_pipe.sv
module hold_sync_pipe #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d,
    output logic [STAGES-1:0] q
);
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) q[0] <= 1'b0;
                    else     q[0] <= d;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) q[i] <= 1'b0;
                    else     q[i] <= q[i-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dma_hold_arbiter.sv
module dma_hold_arbiter
    import hold_arb_pkg::*;
#(
    parameter int REVISION    = 1,
    parameter int ADDR_W      = 10,
    parameter int WIN_BASE    = 0,
    parameter int WIN_SPAN    = 32,
    parameter int HOLD_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_status,
    input  logic              lock_n,
    input  logic              hold_req,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              iow_n,
    output logic              dma_cs_n,
    output logic              hold_ack,
    output logic              cpu_wait
);
    localparam int LAST = HOLD_STAGES - 1;

    logic                   grant;
    logic [HOLD_STAGES-1:0] stage_q;

    hold_cs_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .WIN_SPAN(WIN_SPAN)
    ) u_decode (
        .clk     (clk),
        .rst     (rst),
        .io_addr (io_addr),
        .dma_cs_n(dma_cs_n)
    );

    hold_grant_logic #(
        .REVISION(REVISION)
    ) u_grant (
        .clk       (clk),
        .rst       (rst),
        .bus_status(bus_status),
        .lock_n    (lock_n),
        .hold_req  (hold_req),
        .dma_cs_n  (dma_cs_n),
        .iow_n     (iow_n),
        .grant     (grant)
    );

    hold_sync_pipe #(
        .STAGES(HOLD_STAGES)
    ) u_pipe (
        .clk(clk),
        .rst(rst),
        .d  (grant),
        .q  (stage_q)
    );

    assign hold_ack = stage_q[LAST];
    // The processor is stalled while any stage carries a grant.
    assign cpu_wait = |stage_q;

    // R8: acknowledge never appears without the processor held.
    assert_ack_needs_wait_R8: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> cpu_wait);

    // R8: the wait is released only together with the acknowledge.
    assert_wait_release_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_wait) |-> $fell(hold_ack));

    generate
        if (HOLD_STAGES == 3) begin : g_latency_check
            // R2 and R7: the acknowledge follows the condition by exactly three edges.
            assert_ack_latency_R2: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
                    |-> (hold_ack == $past(grant, 3)));
        end
    endgenerate

endmodule

// File: tb/dma_hold_arbiter_test.sv
module dma_hold_arbiter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_status = 2'b11;
    logic       lock_n = 1'b1;
    logic       hold_req = 1'b0;
    logic [9:0] io_addr = '0;
    logic       iow_n = 1'b1;

    logic cs_r, ack_r, wait_r;
    logic cs_e, ack_e, wait_e;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    dma_hold_arbiter #(.REVISION(1)) uut (
        .clk(clk), .rst(rst), .bus_status(bus_status), .lock_n(lock_n),
        .hold_req(hold_req), .io_addr(io_addr), .iow_n(iow_n),
        .dma_cs_n(cs_r), .hold_ack(ack_r), .cpu_wait(wait_r)
    );

    dma_hold_arbiter #(.REVISION(0)) uut_early (
        .clk(clk), .rst(rst), .bus_status(bus_status), .lock_n(lock_n),
        .hold_req(hold_req), .io_addr(io_addr), .iow_n(iow_n),
        .dma_cs_n(cs_e), .hold_ack(ack_e), .cpu_wait(wait_e)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_bus();
        bus_status = 2'b11;
        lock_n     = 1'b1;
        hold_req   = 1'b0;
        io_addr    = '0;
        iow_n      = 1'b1;
    endtask

    task automatic test_reset();
        hold_req = 1'b1;
        step(4);
        chk("R1", "ack during reset", ack_r, 1'b0);
        chk("R1", "wait during reset", wait_r, 1'b0);
        chk("R1", "early ack during reset", ack_e, 1'b0);
        hold_req = 1'b0;
        rst = 1'b0;
        step(4);
        chk("R1", "ack after reset", ack_r, 1'b0);
        chk("R1", "wait after reset", wait_r, 1'b0);
    endtask

    task automatic test_basic_grant();
        hold_req = 1'b1;
        step(1);
        chk("R8", "wait after first edge", wait_r, 1'b1);
        chk("R2", "ack after first edge", ack_r, 1'b0);
        step(1);
        chk("R2", "ack after second edge", ack_r, 1'b0);
        step(1);
        chk("R2", "ack after third edge", ack_r, 1'b1);
        chk("R2", "early ack after third edge", ack_e, 1'b1);
        hold_req = 1'b0;
        step(2);
        chk("R8", "wait held with ack", wait_r, 1'b1);
        chk("R7", "ack two edges after drop", ack_r, 1'b1);
        step(1);
        chk("R7", "ack three edges after drop", ack_r, 1'b0);
        chk("R8", "wait falls with ack", wait_r, 1'b0);
        idle_bus();
        step(4);
    endtask

    task automatic test_locked();
        lock_n   = 1'b0;
        hold_req = 1'b1;
        step(6);
        chk("R3", "ack while locked", ack_r, 1'b0);
        chk("R3", "early ack while locked", ack_e, 1'b0);
        chk("R3", "wait while locked", wait_r, 1'b0);
        lock_n = 1'b1;
        step(3);
        chk("R2", "delayed grant after unlock", ack_r, 1'b1);
        idle_bus();
        step(4);
    endtask

    task automatic test_active_status();
        bus_status = 2'b00;
        hold_req   = 1'b1;
        step(6);
        chk("R3", "ack in active cycle", ack_r, 1'b0);
        bus_status = 2'b01;
        step(6);
        chk("R3", "ack in other active cycle", ack_e, 1'b0);
        idle_bus();
        step(4);
    endtask

    task automatic test_decode();
        io_addr = 10'h000; #1;
        chk("R6", "select at 0x000", cs_r, 1'b0);
        io_addr = 10'h01F; #1;
        chk("R6", "select at 0x01F", cs_r, 1'b0);
        io_addr = 10'h020; #1;
        chk("R6", "select at 0x020", cs_r, 1'b1);
        io_addr = 10'h3FF; #1;
        chk("R6", "select at 0x3FF", cs_e, 1'b1);
        idle_bus();
        step(2);
    endtask

    task automatic test_write_collision();
        int seen_r = -1;
        int early_hi = 0;
        bus_status = 2'b10;
        io_addr    = 10'h005;
        iow_n      = 1'b0;
        hold_req   = 1'b1;
        for (int c = 1; c <= 40; c++) begin
            step(1);
            if (ack_e) early_hi++;
            if (ack_r && seen_r < 0) seen_r = c;
        end
        chk_int("R4", "revised ack edge during register write", seen_r, 3);
        chk_int("R5", "early ack cycles during register write", early_hi, 0);
        chk("R5", "early processor still waiting on bus", wait_e, 1'b0);
        hold_req   = 1'b0;
        iow_n      = 1'b1;
        bus_status = 2'b11;
        step(3);
        chk("R7", "revised ack released after completion", ack_r, 1'b0);
        idle_bus();
        step(4);
    endtask

    task automatic test_override_edges();
        bus_status = 2'b01;
        iow_n      = 1'b0;
        io_addr    = 10'h01F;
        step(3);
        chk("R4", "write to 0x01F forces ack", ack_r, 1'b1);
        chk("R5", "early ignores write to 0x01F", ack_e, 1'b0);
        io_addr = 10'h020;
        step(3);
        chk("R6", "write to 0x020 no ack", ack_r, 1'b0);
        io_addr = 10'h010;
        iow_n   = 1'b1;
        step(3);
        chk("R4", "select without strobe no ack", ack_r, 1'b0);
        lock_n = 1'b0;
        iow_n  = 1'b0;
        step(3);
        chk("R4", "write overrides lock", ack_r, 1'b1);
        idle_bus();
        step(4);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_basic_grant();
        test_locked();
        test_active_status();
        test_decode();
        test_write_collision();
        test_override_edges();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule